// File: doc/BRIEF.md
# Fracturable LUT Logic Element

This block is one logic element of a small programmable fabric. It holds a 16-entry truth table, two D flip-flops and a small set of static configuration inputs. Those inputs pick how the element works: as one 4-input function with a single register, as two separate 3-input functions with one register each, or as a 2-bit shift register that can be cascaded with neighbouring elements through a chain input and a chain output.

A test-enable input overrides whichever mode is selected and joins the two flip-flops into a serial scan segment. The register contents can then be loaded from the scan input and read back at the scan output. Each of the two data outputs has its own configuration bit. That bit chooses between the combinational function result and the registered value.

Top module: `flc_top`

## Requirements
- R1: With cfg_mode 2'b00 or 2'b11 (full mode) and test_en low, the function result is cfg_truth[lut_in], where lut_in is read as an unsigned index so that lut_in[3] picks the upper eight entries. Flip-flop 0 captures this result on every rising edge, and flip-flop 1 holds its value.
- R2: With cfg_mode 2'b01 (split mode) and test_en low, the low function is cfg_truth[lut_in[2:0]] and the high function is cfg_truth[8 + lut_in[2:0]]. lut_in[3] has no effect. Flip-flop 0 captures the low function and flip-flop 1 captures the high function.
- R3: In full and split modes, cfg_reg_sel[k] = 1 makes dout[k] show flip-flop k, and cfg_reg_sel[k] = 0 makes it show the combinational result. For dout[0] that result is the 4-input function in full mode and the low function in split mode. For dout[1] it is the high function in split mode.
- R4: With cfg_mode 2'b10 (shift mode) and test_en low, flip-flop 0 loads chain_in and flip-flop 1 loads flip-flop 0 on each edge. dout[0] shows flip-flop 0 and dout[1] shows flip-flop 1, whatever cfg_reg_sel holds.
- R5: In full mode dout[1] is 0.
- R6: While test_en is high, in any mode, flip-flop 0 loads scan_in and flip-flop 1 loads flip-flop 0 on each edge. A bit shifted in therefore reaches scan_out two edges later.
- R7: A rising edge with rst_n low clears both flip-flops to 0. This takes priority over test_en and over the mode.
- R8: scan_out and chain_out both show flip-flop 1 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of both flip-flops |
| cfg_truth | input | 16 | Truth table, entry i at bit i |
| cfg_mode | input | 2 | 00/11 full, 01 split, 10 shift |
| cfg_reg_sel | input | 2 | Per-output select: 1 registered, 0 combinational |
| lut_in | input | 4 | Function inputs |
| test_en | input | 1 | Scan override |
| scan_in | input | 1 | Serial scan input |
| scan_out | output | 1 | Serial scan output (flip-flop 1) |
| chain_in | input | 1 | Shift-register cascade input |
| chain_out | output | 1 | Shift-register cascade output (flip-flop 1) |
| dout | output | 2 | Data outputs |

## Verification
Combinational outputs follow lut_in, cfg_truth and the mode selection in the same cycle. Each register captures on the first rising edge after its inputs settle, so a registered output or scan_out shows a new value one edge later. In scan and shift modes a bit entering at the serial input appears at the serial outputs two edges later. The bench drives every input on the falling edge and compares all outputs against its reference state 1 ns later. It advances that reference state only after the following rising edge, so each value is checked in the cycle it is due.

// File: rtl/flc_pkg.sv
// Package: shared mode encoding for the fracturable LUT element.
// Assumes a 2-bit mode field; code 3 behaves like the full-LUT mode.
package flc_pkg;

    typedef enum logic [1:0] {
        FLC_FULL     = 2'b00,
        FLC_SPLIT    = 2'b01,
        FLC_SHIFT    = 2'b10,
        FLC_FULL_ALT = 2'b11
    } flc_mode_e;

    // True when the mode maps one K-input function onto flip-flop 0.
    function automatic logic is_full(input flc_mode_e m);
        return (m == FLC_FULL) || (m == FLC_FULL_ALT);
    endfunction

endpackage

// File: rtl/flc_lut_frac.sv
// Module: fracturable look-up table.
// Produces the full K-input result and the two (K-1)-input half results.
// Assumes the table holds entry i at bit i; the upper half starts at 2**(K-1).
module flc_lut_frac #(
    parameter int LUT_K = 4
) (
    input  logic [(1 << LUT_K)-1:0] truth,
    input  logic [LUT_K-1:0]        sel,
    output logic [1:0]              half_q,
    output logic                    full_q
);
    localparam int HALF_W = 1 << (LUT_K - 1);

    logic [HALF_W-1:0] half_tab [2];

    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            // Slice one half of the table and index it with the low inputs.
            always_comb begin
                half_tab[h] = truth[h*HALF_W +: HALF_W];
                half_q[h]   = half_tab[h][sel[LUT_K-2:0]];
            end
        end
    endgenerate

    // The top input chooses between the two halves.
    always_comb full_q = sel[LUT_K-1] ? half_q[1] : half_q[0];

endmodule

// File: rtl/flc_ff_pair.sv
// Module: the two flip-flops and their next-state selection.
// Priority: reset, then the scan override, then the mode.
// Reset is synchronous and active low.
module flc_ff_pair
    import flc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      test_en,
    input  flc_mode_e mode,
    input  logic      scan_in,
    input  logic      chain_in,
    input  logic      full_q,
    input  logic [1:0] half_q,
    output logic [1:0] ff_q
);
    logic [1:0] ff_d;

    // Choose what each flip-flop loads on the next edge.
    always_comb begin
        if (test_en) begin
            ff_d = {ff_q[0], scan_in};
        end else begin
            unique case (mode)
                FLC_SPLIT: ff_d = half_q;
                FLC_SHIFT: ff_d = {ff_q[0], chain_in};
                default:   ff_d = {ff_q[1], full_q};
            endcase
        end
    end

    // Register the selected values, clearing them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

endmodule

// File: rtl/flc_out_mux.sv
// Module: output selection.
// Each output picks the combinational or the registered value per its select bit.
// The shift mode always shows the register taps; the full mode ties output 1 low.
module flc_out_mux
    import flc_pkg::*;
(
    input  flc_mode_e  mode,
    input  logic [1:0] reg_sel,
    input  logic [1:0] ff_q,
    input  logic       full_q,
    input  logic [1:0] half_q,
    output logic [1:0] dout
);
    logic [1:0] comb_v;

    // Combinational value offered to each output in the current mode.
    always_comb begin
        comb_v[0] = is_full(mode) ? full_q : half_q[0];
        comb_v[1] = half_q[1];
    end

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_out
            // Final selection for output k.
            always_comb begin
                if (mode == FLC_SHIFT)                 dout[k] = ff_q[k];
                else if (k == 1 && is_full(mode))      dout[k] = 1'b0;
                else if (reg_sel[k])                   dout[k] = ff_q[k];
                else                                   dout[k] = comb_v[k];
            end
        end
    endgenerate

endmodule

// File: rtl/flc_top.sv
// Module: fracturable LUT logic element (top).
// Joins the table, the flip-flop pair and the output selection.
// Assumes the configuration inputs are static during normal operation.
module flc_top
    import flc_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [(1 << LUT_K)-1:0] cfg_truth,
    input  logic [1:0]              cfg_mode,
    input  logic [1:0]              cfg_reg_sel,
    input  logic [LUT_K-1:0]        lut_in,
    input  logic                    test_en,
    input  logic                    scan_in,
    output logic                    scan_out,
    input  logic                    chain_in,
    output logic                    chain_out,
    output logic [1:0]              dout
);
    flc_mode_e  mode;
    logic       full_q;
    logic [1:0] half_q;
    logic [1:0] ff_q;

    // Decode the raw mode field.
    always_comb mode = flc_mode_e'(cfg_mode);

    flc_lut_frac #(.LUT_K(LUT_K)) lut_i (
        .truth  (cfg_truth),
        .sel    (lut_in),
        .half_q (half_q),
        .full_q (full_q)
    );

    flc_ff_pair ff_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_en  (test_en),
        .mode     (mode),
        .scan_in  (scan_in),
        .chain_in (chain_in),
        .full_q   (full_q),
        .half_q   (half_q),
        .ff_q     (ff_q)
    );

    flc_out_mux out_i (
        .mode    (mode),
        .reg_sel (cfg_reg_sel),
        .ff_q    (ff_q),
        .full_q  (full_q),
        .half_q  (half_q),
        .dout    (dout)
    );

    // Both serial outputs come from the last flip-flop.
    always_comb begin
        scan_out  = ff_q[1];
        chain_out = ff_q[1];
    end

endmodule

// File: rtl/flc_checker.sv
// Module: assertion checker for flc_top, attached through bind.
// Relates the flip-flop state to the inputs of the previous edge.
module flc_checker #(
    parameter int LUT_K = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [(1 << LUT_K)-1:0] cfg_truth,
    input logic [1:0]              cfg_mode,
    input logic [LUT_K-1:0]        lut_in,
    input logic                    test_en,
    input logic                    scan_in,
    input logic                    chain_in,
    input logic [1:0]              ff_q
);
    localparam int HALF_W = 1 << (LUT_K - 1);

    logic [LUT_K-1:0] hi_idx;
    always_comb hi_idx = LUT_K'(HALF_W) + LUT_K'(lut_in[LUT_K-2:0]);

    // R7: reset clears both flip-flops.
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ff_q == 2'b00);

    // R6: scan override shifts scan_in through both flip-flops.
    a_r6_scan_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && test_en) |=> (ff_q[0] == $past(scan_in)) && (ff_q[1] == $past(ff_q[0])));

    // R4: shift mode moves chain_in along.
    a_r4_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !test_en && cfg_mode == 2'b10)
        |=> (ff_q[0] == $past(chain_in)) && (ff_q[1] == $past(ff_q[0])));

    // R2: split mode registers the two half functions.
    a_r2_split_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !test_en && cfg_mode == 2'b01)
        |=> (ff_q[0] == $past(cfg_truth[lut_in[LUT_K-2:0]]))
            && (ff_q[1] == $past(cfg_truth[hi_idx])));

    // R1: full mode registers the K-input function and holds flip-flop 1.
    a_r1_full_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !test_en && (cfg_mode == 2'b00 || cfg_mode == 2'b11))
        |=> (ff_q[0] == $past(cfg_truth[lut_in])) && $stable(ff_q[1]));

endmodule

bind flc_top flc_checker #(.LUT_K(LUT_K)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_truth (cfg_truth),
    .cfg_mode  (cfg_mode),
    .lut_in    (lut_in),
    .test_en   (test_en),
    .scan_in   (scan_in),
    .chain_in  (chain_in),
    .ff_q      (ff_q)
);

// File: tb/flc_top_tb_top.sv
// Bench: behavioural reference model of the logic element, compared every cycle.
module flc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_truth;
    logic [1:0]  cfg_mode;
    logic [1:0]  cfg_reg_sel;
    logic [3:0]  lut_in;
    logic        test_en;
    logic        scan_in;
    logic        scan_out;
    logic        chain_in;
    logic        chain_out;
    logic [1:0]  dout;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state: the two register bits.
    bit m0 = 0, m1 = 0;

    always #4 clk = ~clk;

    flc_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_truth(cfg_truth), .cfg_mode(cfg_mode),
        .cfg_reg_sel(cfg_reg_sel), .lut_in(lut_in), .test_en(test_en),
        .scan_in(scan_in), .scan_out(scan_out), .chain_in(chain_in),
        .chain_out(chain_out), .dout(dout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs with the model, then advance the model over one edge.
    task automatic step();
        bit full, lo, hi, e0, e1, n0, n1;
        string t0, t1;
        #1;
        full = cfg_truth[lut_in];
        lo   = cfg_truth[lut_in[2:0]];
        hi   = cfg_truth[8 + lut_in[2:0]];
        if (cfg_mode == 2'b10) begin
            e0 = m0; e1 = m1; t0 = "R4"; t1 = "R4";
        end else if (cfg_mode == 2'b01) begin
            e0 = cfg_reg_sel[0] ? m0 : lo;
            e1 = cfg_reg_sel[1] ? m1 : hi;
            t0 = cfg_reg_sel[0] ? "R3" : "R2";
            t1 = cfg_reg_sel[1] ? "R3" : "R2";
        end else begin
            e0 = cfg_reg_sel[0] ? m0 : full;
            e1 = 1'b0;
            t0 = cfg_reg_sel[0] ? "R3" : "R1";
            t1 = "R5";
        end
        check(t0, dout[0], e0);
        check(t1, dout[1], e1);
        check("R8 scan_out", scan_out, m1);
        check("R8 chain_out", chain_out, m1);
        if (!rst_n)             begin n0 = 0;        n1 = 0;  end
        else if (test_en)       begin n0 = scan_in;  n1 = m0; end
        else if (cfg_mode == 2'b01) begin n0 = lo;   n1 = hi; end
        else if (cfg_mode == 2'b10) begin n0 = chain_in; n1 = m0; end
        else                    begin n0 = full;     n1 = m1; end
        @(posedge clk);
        m0 = n0; m1 = n1;
        @(negedge clk);
    endtask

    task automatic rand_inputs(input int te_pct);
        lut_in   = 4'($urandom);
        scan_in  = 1'($urandom);
        chain_in = 1'($urandom);
        test_en  = (($urandom % 100) < te_pct);
    endtask

    initial begin
        rst_n = 0; cfg_truth = 16'h0; cfg_mode = 2'b00; cfg_reg_sel = 2'b11;
        lut_in = 4'h0; test_en = 0; scan_in = 1; chain_in = 1;
        @(negedge clk);
        step();
        // R7: reset state visible on registered outputs and serial outputs.
        #1;
        check("R7 reset dout0", dout[0], 1'b0);
        check("R7 reset scan_out", scan_out, 1'b0);
        rst_n = 1;

        // Random sweep of every mode code, select pattern and truth table.
        for (int mode = 0; mode < 4; mode++) begin
            for (int blk = 0; blk < 16; blk++) begin
                cfg_mode    = 2'(mode);
                cfg_reg_sel = 2'(blk);
                cfg_truth   = 16'($urandom);
                for (int c = 0; c < 40; c++) begin
                    rand_inputs(10);
                    step();
                end
            end
        end

        // R7: reset mid-run takes priority over scan.
        cfg_mode = 2'b01; cfg_reg_sel = 2'b11;
        test_en = 1; scan_in = 1; rst_n = 0;
        step();
        step();
        rst_n = 1;

        // R6: shift a known pattern through the scan path and read it back.
        begin
            bit [11:0] pat = 12'b1011_0010_1110;
            cfg_mode = 2'b00; test_en = 1;
            for (int i = 0; i < 14; i++) begin
                scan_in = (i < 12) ? pat[i] : 1'b0;
                #1;
                if (i >= 2) check("R6 scan readback", scan_out, pat[i-2]);
                step();
            end
        end

        // R2: lut_in[3] has no effect in split mode.
        cfg_mode = 2'b01; cfg_reg_sel = 2'b00; test_en = 0; cfg_truth = 16'hA5C3;
        for (int i = 0; i < 8; i++) begin
            lut_in = 4'(i);
            #1;
            check("R2 low ignores in3", dout[0], cfg_truth[i]);
            lut_in = 4'(i + 8);
            #1;
            check("R2 low ignores in3", dout[0], cfg_truth[i]);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule